// File: doc/BRIEF.md
# Packet Page Allocator and Queue Manager

This block keeps track of a small pool of fixed-size frame buffer pages for an Ethernet controller. It owns the map of which pages are in use, a transmit queue, a receive queue and a transmit-completion queue. It also holds an interrupt status byte and an interrupt mask byte, and it drives one level interrupt output. The buffer memory and the serializer are outside the block. Transmission is seen only as a one-cycle strobe that carries the page number leaving the transmit queue.

Software uses a byte-wide register port. A command byte carries a 3-bit operation in bits 7:5. Three more write strobes load the packet-number byte, the interrupt acknowledge byte and the mask byte. Reads are continuous outputs: the allocation result, the completion-queue head, the receive-queue head, the count of used pages, the pool size, and the status and mask bytes. The receive datapath asks for a page with a one-cycle request. It gets an answer in the next cycle.

An allocation for transmit that finds the pool full is not lost. It stays pending and is retried each cycle until a page is free.

Top module: `pkt_page_mgr`

## Requirements
- R1: After reset:
  - no page is used and the alloc result reads 0x00;
  - both queue heads read 0x80;
  - status is 0x04 and the mask is 0x00;
  - irq is low;
  - the pool size reads NUM_PAGES (4).
- R2: Command code 1 (bits 7:5 = 3'b001) takes the lowest-numbered free page. The page number appears on the alloc result after the write edge, and status bit 3 (ALLOC) is set.
- R3: Command code 1 on a full pool clears ALLOC and makes the result 0x80. The request stays pending. In the cycle after a release, the lowest free page is granted and ALLOC is set.
- R4: The used-count output always equals the number of allocated pages.
- R5: Each receive request is answered one cycle later with rx_ack.
  - When a page is free, rx_ok is high, rx_page holds the page number, the page is pushed onto the receive queue and status bit 0 (RCV) is set.
  - When the pool is full, rx_ok is low and rx_page is 0x80.
  - When a request and code 1 fall in the same cycle, transmit gets the lowest free page and receive gets the next one.
- R6: Command code 3 pops the receive queue. Code 4 first releases the receive head page and then pops. After a pop, RCV is set if entries remain and cleared if the queue is empty. A pop of an empty queue changes nothing.
- R7: Code 5 releases the page named by the low bits of the packet-number byte. Code 6 enqueues that page for transmit. An enqueue to a full transmit queue, with no entry leaving in that cycle, is ignored.
- R8: While tx_en is high, the transmit queue drains one page per cycle in FIFO order. tx_send and tx_page appear one cycle after the dequeue. Status bit 2 (TX_EMPTY) is set whenever the transmit queue is empty.
- R9: Where a sent page goes depends on auto_release:
  - with auto_release high, the sent page is freed;
  - otherwise it is pushed onto the completion queue.
  The completion head reads 0x80 when the queue is empty. Status bit 1 (TX) is set while the queue is non-empty.
- R10: An acknowledge write clears status bits (value AND 0xD6). If bit 1 of the value is set, it also pops one completion entry. ALLOC, EPH and RCV are never cleared this way. TX and TX_EMPTY are set again if their condition still holds.
- R11: irq is high exactly when (status AND mask) is nonzero.
- R12: Code 2 frees every page, empties all three queues, sets the result to 0x00 and drops any pending allocation. Code 7 empties the transmit and completion queues and leaves the pages allocated.
- R13: Bits 4:0 of the command byte have no effect, and code 0 changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_we | input | 1 | Command byte write strobe |
| cmd_byte | input | 8 | Command byte, operation in bits 7:5 |
| pnum_we | input | 1 | Packet-number write strobe |
| pnum_byte | input | 8 | Packet-number value |
| ack_we | input | 1 | Interrupt acknowledge write strobe |
| ack_byte | input | 8 | Acknowledge value |
| mask_we | input | 1 | Interrupt mask write strobe |
| mask_byte | input | 8 | New mask value |
| tx_en | input | 1 | Transmit enable |
| auto_release | input | 1 | Free pages once sent |
| rx_req | input | 1 | Receive page request |
| rx_ack | output | 1 | Receive request answered |
| rx_ok | output | 1 | Receive request granted |
| rx_page | output | 8 | Granted page or 0x80 |
| tx_send | output | 1 | Page sent strobe |
| tx_page | output | PG_W | Sent page number |
| alloc_result | output | 8 | Transmit allocation result |
| done_head | output | 8 | Completion queue head or 0x80 |
| rx_head | output | 8 | Receive queue head or 0x80 |
| used_count | output | 8 | Number of allocated pages |
| mem_size | output | 8 | Pool size in pages |
| irq_status | output | 8 | Interrupt status byte |
| irq_mask | output | 8 | Interrupt mask byte |
| irq | output | 1 | Interrupt output |

## Verification
Two allocations can fall in the same cycle: a transmit allocate command and a receive page request. They compete for the lowest free page. The bench writes command code 1 and raises rx_req on the same edge after a reset. It then requires the allocation result to read page 0 and the receive answer to carry page 1, so the two grants are distinct. A sweep over all sixteen occupancy patterns checks that the transmit grant always lands on the lowest free page. The pending-retry test checks that a release is followed one cycle later by the deferred grant.

// File: rtl/pp_pkg.sv
package pp_pkg;

    typedef enum logic [2:0] {
        OP_NOP     = 3'd0,
        OP_TXALLOC = 3'd1,
        OP_RESET   = 3'd2,
        OP_RXPOP   = 3'd3,
        OP_RXREL   = 3'd4,
        OP_REL     = 3'd5,
        OP_TXQ     = 3'd6,
        OP_TXCLR   = 3'd7
    } mmu_op_e;

    localparam int ST_RCV      = 0;
    localparam int ST_TX       = 1;
    localparam int ST_TXEMPTY  = 2;
    localparam int ST_ALLOC    = 3;

    localparam logic [7:0] ACK_CLEARABLE = 8'hD6;
    localparam logic [7:0] NONE_CODE     = 8'h80;

endpackage

// File: rtl/pp_lowfree.sv
module pp_lowfree #(
    parameter int N  = 4,
    parameter int IW = 2
) (
    input  logic [N-1:0]  free_i,
    output logic          vld_o,
    output logic [IW-1:0] idx_o
);
    always_comb begin
        vld_o = 1'b0;
        idx_o = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (free_i[i]) begin
                vld_o = 1'b1;
                idx_o = IW'(i);
            end
        end
    end
endmodule

// File: rtl/pp_queue.sv
module pp_queue #(
    parameter int DEPTH = 4,
    parameter int W     = 2
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         clr,
    input  logic                         push,
    input  logic [W-1:0]                 push_data,
    input  logic                         pop,
    output logic [W-1:0]                 head,
    output logic [$clog2(DEPTH+1)-1:0]   cnt,
    output logic [$clog2(DEPTH+1)-1:0]   cnt_next
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    typedef struct packed {
        logic [DEPTH-1:0][W-1:0] mem;
        logic [AW-1:0]           rd;
        logic [CW-1:0]           cnt;
    } q_state_t;

    q_state_t q_d, q_q;
    logic do_pop, do_push;
    int   wr_i;
    int   rd_i;

    always_comb begin
        q_d     = q_q;
        do_pop  = pop && (q_q.cnt != '0);
        do_push = push && ((int'(q_q.cnt) < DEPTH) || do_pop);
        wr_i    = (int'(q_q.rd) + int'(q_q.cnt)) % DEPTH;
        rd_i    = (int'(q_q.rd) + 1) % DEPTH;
        if (clr) begin
            q_d.rd  = '0;
            q_d.cnt = '0;
        end else begin
            if (do_push) q_d.mem[wr_i[AW-1:0]] = push_data;
            if (do_pop)  q_d.rd = rd_i[AW-1:0];
            q_d.cnt = q_q.cnt + CW'(do_push) - CW'(do_pop);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q_q <= '0;
        else        q_q <= q_d;
    end

    assign head     = q_q.mem[q_q.rd];
    assign cnt      = q_q.cnt;
    assign cnt_next = q_d.cnt;

    // R6
    pop_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && q_q.cnt == '0 && !push && !clr) |=> (q_q.cnt == '0));

    // R7
    no_overfill_chk: assert property (@(posedge clk) disable iff (!rst_n)
        int'(q_q.cnt) <= DEPTH);
endmodule

// File: rtl/pkt_page_mgr.sv
module pkt_page_mgr
    import pp_pkg::*;
#(
    parameter int NUM_PAGES = 4,
    parameter int PG_W      = $clog2(NUM_PAGES)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            cmd_we,
    input  logic [7:0]      cmd_byte,
    input  logic            pnum_we,
    input  logic [7:0]      pnum_byte,
    input  logic            ack_we,
    input  logic [7:0]      ack_byte,
    input  logic            mask_we,
    input  logic [7:0]      mask_byte,
    input  logic            tx_en,
    input  logic            auto_release,
    input  logic            rx_req,
    output logic            rx_ack,
    output logic            rx_ok,
    output logic [7:0]      rx_page,
    output logic            tx_send,
    output logic [PG_W-1:0] tx_page,
    output logic [7:0]      alloc_result,
    output logic [7:0]      done_head,
    output logic [7:0]      rx_head,
    output logic [7:0]      used_count,
    output logic [7:0]      mem_size,
    output logic [7:0]      irq_status,
    output logic [7:0]      irq_mask,
    output logic            irq
);
    localparam int CW = $clog2(NUM_PAGES + 1);

    typedef struct packed {
        logic [NUM_PAGES-1:0] alloc;
        logic                 pend;
        logic [7:0]           result;
        logic [7:0]           status;
        logic [7:0]           mask;
        logic [7:0]           pnum;
        logic                 tx_send;
        logic [PG_W-1:0]      tx_page;
        logic                 rx_ack;
        logic                 rx_ok;
        logic [7:0]           rx_page;
    } mgr_state_t;

    mgr_state_t s_d, s_q;

    mmu_op_e op;
    logic op_txalloc, op_reset, op_rxpop, op_rxrel, op_rel, op_txq, op_txclr;
    logic tx_try, tx_take, rx_take, drain;
    logic g0_vld, g1_vld;
    logic [PG_W-1:0] g0_idx, g1_idx, rx_idx, pnum_pg;
    logic [NUM_PAGES-1:0] free0, free1, rel_mask, set_mask;

    logic [PG_W-1:0] txq_head, doneq_head, rxq_head;
    logic [CW-1:0]   txq_cnt, txq_cnt_nx, doneq_cnt, doneq_cnt_nx, rxq_cnt, rxq_cnt_nx;
    logic txq_push, txq_pop, txq_clr, doneq_push, doneq_pop, rxq_pop;

    logic unused_bits;
    assign unused_bits = ^{cmd_byte[4:0], s_q.pnum};

    assign op         = mmu_op_e'(cmd_byte[7:5]);
    assign op_txalloc = cmd_we && op == OP_TXALLOC;
    assign op_reset   = cmd_we && op == OP_RESET;
    assign op_rxpop   = cmd_we && op == OP_RXPOP;
    assign op_rxrel   = cmd_we && op == OP_RXREL;
    assign op_rel     = cmd_we && op == OP_REL;
    assign op_txq     = cmd_we && op == OP_TXQ;
    assign op_txclr   = cmd_we && op == OP_TXCLR;
    assign pnum_pg    = s_q.pnum[PG_W-1:0];

    assign free0   = ~s_q.alloc;
    assign tx_try  = op_txalloc || (s_q.pend && !op_reset);
    assign tx_take = tx_try && g0_vld;
    assign free1   = free0 & ~(tx_take ? (NUM_PAGES'(1) << g0_idx) : '0);

    pp_lowfree #(.N(NUM_PAGES), .IW(PG_W)) u_low_tx (
        .free_i(free0), .vld_o(g0_vld), .idx_o(g0_idx));
    pp_lowfree #(.N(NUM_PAGES), .IW(PG_W)) u_low_rx (
        .free_i(free1), .vld_o(g1_vld), .idx_o(g1_idx));

    assign rx_take = rx_req && !op_reset && g1_vld;
    assign rx_idx  = g1_idx;
    assign drain   = tx_en && (txq_cnt != '0) && !op_reset && !op_txclr;

    assign txq_push   = op_txq;
    assign txq_pop    = drain;
    assign txq_clr    = op_reset || op_txclr;
    assign doneq_push = drain && !auto_release;
    assign doneq_pop  = ack_we && ack_byte[ST_TX];
    assign rxq_pop    = op_rxpop || op_rxrel;

    pp_queue #(.DEPTH(NUM_PAGES), .W(PG_W)) u_txq (
        .clk(clk), .rst_n(rst_n), .clr(txq_clr), .push(txq_push),
        .push_data(pnum_pg), .pop(txq_pop), .head(txq_head),
        .cnt(txq_cnt), .cnt_next(txq_cnt_nx));
    pp_queue #(.DEPTH(NUM_PAGES), .W(PG_W)) u_doneq (
        .clk(clk), .rst_n(rst_n), .clr(txq_clr), .push(doneq_push),
        .push_data(txq_head), .pop(doneq_pop), .head(doneq_head),
        .cnt(doneq_cnt), .cnt_next(doneq_cnt_nx));
    pp_queue #(.DEPTH(NUM_PAGES), .W(PG_W)) u_rxq (
        .clk(clk), .rst_n(rst_n), .clr(op_reset), .push(rx_take),
        .push_data(rx_idx), .pop(rxq_pop), .head(rxq_head),
        .cnt(rxq_cnt), .cnt_next(rxq_cnt_nx));

    always_comb begin
        s_d = s_q;

        rel_mask = '0;
        if (op_rel) rel_mask |= NUM_PAGES'(1) << pnum_pg;
        if (op_rxrel && rxq_cnt != '0) rel_mask |= NUM_PAGES'(1) << rxq_head;
        if (drain && auto_release) rel_mask |= NUM_PAGES'(1) << txq_head;
        set_mask = '0;
        if (tx_take) set_mask |= NUM_PAGES'(1) << g0_idx;
        if (rx_take) set_mask |= NUM_PAGES'(1) << rx_idx;

        if (op_reset) begin
            s_d.alloc  = '0;
            s_d.pend   = 1'b0;
            s_d.result = 8'h00;
        end else begin
            s_d.alloc = (s_q.alloc & ~rel_mask) | set_mask;
            if (tx_try) begin
                s_d.pend   = !tx_take;
                s_d.result = tx_take ? 8'(g0_idx) : NONE_CODE;
            end
        end

        if (op_txalloc) s_d.status[ST_ALLOC] = 1'b0;
        if (tx_take)    s_d.status[ST_ALLOC] = 1'b1;
        if (ack_we)     s_d.status = s_d.status & ~(ack_byte & ACK_CLEARABLE);
        if (rxq_pop)    s_d.status[ST_RCV] = (rxq_cnt_nx != '0);
        if (rx_take)    s_d.status[ST_RCV] = 1'b1;
        if (txq_cnt_nx == '0)   s_d.status[ST_TXEMPTY] = 1'b1;
        if (doneq_cnt_nx != '0) s_d.status[ST_TX] = 1'b1;

        if (mask_we) s_d.mask = mask_byte;
        if (pnum_we) s_d.pnum = pnum_byte;

        s_d.tx_send = drain;
        s_d.tx_page = txq_head;
        s_d.rx_ack  = rx_req;
        s_d.rx_ok   = rx_take;
        s_d.rx_page = rx_take ? 8'(rx_idx) : NONE_CODE;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q        <= '0;
            s_q.status <= 8'(1 << ST_TXEMPTY);
        end else begin
            s_q <= s_d;
        end
    end

    assign rx_ack       = s_q.rx_ack;
    assign rx_ok        = s_q.rx_ok;
    assign rx_page      = s_q.rx_page;
    assign tx_send      = s_q.tx_send;
    assign tx_page      = s_q.tx_page;
    assign alloc_result = s_q.result;
    assign done_head    = (doneq_cnt == '0) ? NONE_CODE : 8'(doneq_head);
    assign rx_head      = (rxq_cnt == '0) ? NONE_CODE : 8'(rxq_head);
    assign used_count   = 8'($countones(s_q.alloc));
    assign mem_size     = 8'(NUM_PAGES);
    assign irq_status   = s_q.status;
    assign irq_mask     = s_q.mask;
    assign irq          = |(s_q.status & s_q.mask);

    // R8
    tx_empty_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (txq_cnt == '0) |-> s_q.status[ST_TXEMPTY]);

    // R9
    done_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (doneq_cnt != '0) |-> s_q.status[ST_TX]);

    // R2
    grant_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tx_take |-> !s_q.alloc[g0_idx]);

    // R5
    distinct_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_take && rx_take) |-> (g0_idx != rx_idx));

    // R3
    pending_retry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.pend && !(&s_q.alloc)) |=> !s_q.pend);

    // R12
    reset_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        op_reset |=> (s_q.alloc == '0 && s_q.result == 8'h00 && !s_q.pend));
endmodule

// File: tb/pkt_page_mgr_tb.sv
`timescale 1ns/1ps
module pkt_page_mgr_tb_top;
    localparam int NP = 4;
    localparam int PW = 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cmd_we = 0, pnum_we = 0, ack_we = 0, mask_we = 0;
    logic [7:0] cmd_byte = 0, pnum_byte = 0, ack_byte = 0, mask_byte = 0;
    logic tx_en = 0, auto_release = 0, rx_req = 0;
    logic rx_ack, rx_ok, tx_send, irq;
    logic [7:0] rx_page, alloc_result, done_head, rx_head, used_count, mem_size;
    logic [7:0] irq_status, irq_mask;
    logic [PW-1:0] tx_page;

    int total = 0;
    int fails = 0;
    int nsent = 0;
    int sent [16];
    bit finished = 0;

    always #2 clk = ~clk;

    pkt_page_mgr #(.NUM_PAGES(NP)) dut_i (
        .clk(clk), .rst_n(rst_n), .cmd_we(cmd_we), .cmd_byte(cmd_byte),
        .pnum_we(pnum_we), .pnum_byte(pnum_byte), .ack_we(ack_we),
        .ack_byte(ack_byte), .mask_we(mask_we), .mask_byte(mask_byte),
        .tx_en(tx_en), .auto_release(auto_release), .rx_req(rx_req),
        .rx_ack(rx_ack), .rx_ok(rx_ok), .rx_page(rx_page),
        .tx_send(tx_send), .tx_page(tx_page), .alloc_result(alloc_result),
        .done_head(done_head), .rx_head(rx_head), .used_count(used_count),
        .mem_size(mem_size), .irq_status(irq_status), .irq_mask(irq_mask),
        .irq(irq));

    always @(negedge clk) begin
        if (rst_n && tx_send && nsent < 16) begin
            sent[nsent] = int'(tx_page);
            nsent++;
        end
    end

    task automatic chk(input string tag, input int got, input int exp);
        total++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, got, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic cmd(input logic [7:0] b);
        @(negedge clk); cmd_we = 1; cmd_byte = b;
        @(negedge clk); cmd_we = 0;
    endtask

    task automatic pnum(input logic [7:0] b);
        @(negedge clk); pnum_we = 1; pnum_byte = b;
        @(negedge clk); pnum_we = 0;
    endtask

    task automatic ack(input logic [7:0] b);
        @(negedge clk); ack_we = 1; ack_byte = b;
        @(negedge clk); ack_we = 0;
    endtask

    task automatic setmask(input logic [7:0] b);
        @(negedge clk); mask_we = 1; mask_byte = b;
        @(negedge clk); mask_we = 0;
    endtask

    task automatic rxreq();
        @(negedge clk); rx_req = 1;
        @(negedge clk); rx_req = 0;
    endtask

    initial begin
        #(4 * 100000);
        if (!finished) begin
            total++; fails++;
            $display("FAIL watchdog all actual=hung expected=done");
            $display("%0d/%0d checks passed", total - fails, total);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1;

        chk("R1 used", used_count, 0);
        chk("R1 result", alloc_result, 0);
        chk("R1 done_head", done_head, 8'h80);
        chk("R1 rx_head", rx_head, 8'h80);
        chk("R1 status", irq_status, 8'h04);
        chk("R1 mask", irq_mask, 0);
        chk("R1 irq", irq, 0);
        chk("R1 mem_size", mem_size, NP);

        // R2 R3 R4 R7 sweep over every occupancy pattern
        for (int m = 0; m < 16; m++) begin
            int exp_low;
            cmd(8'h40);
            for (int p = 0; p < NP; p++) begin
                cmd(8'h20);
                chk("R2 lowest grant", alloc_result, p);
            end
            chk("R2 alloc flag", irq_status[3], 1);
            for (int p = 0; p < NP; p++) begin
                if (!m[p]) begin
                    pnum(8'(p));
                    cmd(8'hA0);
                end
            end
            chk("R4 used count", used_count, $countones(4'(m)));
            exp_low = 8'h80;
            for (int p = NP - 1; p >= 0; p--) if (!m[p]) exp_low = p;
            cmd(8'h20);
            chk("R2/R3 sweep result", alloc_result, exp_low);
        end

        // R3 pending retry
        cmd(8'h40);
        repeat (NP) cmd(8'h20);
        cmd(8'h20);
        chk("R3 fail code", alloc_result, 8'h80);
        chk("R3 alloc cleared", irq_status[3], 0);
        pnum(8'd2);
        cmd(8'hA0);
        chk("R3 still pending", alloc_result, 8'h80);
        idle(1);
        chk("R3 retry grant", alloc_result, 2);
        chk("R3 alloc set", irq_status[3], 1);
        chk("R4 full again", used_count, 4);

        // R5 refusal on full pool
        rxreq();
        chk("R5 ack", rx_ack, 1);
        chk("R5 refused ok", rx_ok, 0);
        chk("R5 refused page", rx_page, 8'h80);

        // R5 same-cycle tx alloc and rx request
        cmd(8'h40);
        @(negedge clk); rx_req = 1; cmd_we = 1; cmd_byte = 8'h20;
        @(negedge clk); rx_req = 0; cmd_we = 0;
        chk("R5 tx gets lowest", alloc_result, 0);
        chk("R5 rx gets next", rx_page, 1);
        chk("R5 rx ok", rx_ok, 1);
        chk("R5 rx head", rx_head, 1);
        chk("R5 rcv set", irq_status[0], 1);

        // R6 receive pops
        cmd(8'h40);
        rxreq(); rxreq();
        chk("R6 head first", rx_head, 0);
        cmd(8'h80);
        chk("R6 release pop head", rx_head, 1);
        chk("R6 rcv kept", irq_status[0], 1);
        chk("R6 release freed", used_count, 1);
        cmd(8'h60);
        chk("R6 pop empty head", rx_head, 8'h80);
        chk("R6 rcv cleared", irq_status[0], 0);
        cmd(8'h60);
        chk("R6 pop on empty", rx_head, 8'h80);
        chk("R6 pop keeps pages", used_count, 1);

        // R8 R9 R10 R11 drain into completion queue
        cmd(8'h40);
        repeat (3) cmd(8'h20);
        pnum(8'd2); cmd(8'hC0);
        pnum(8'd0); cmd(8'hC0);
        pnum(8'd1); cmd(8'hC0);
        ack(8'h04);
        chk("R8 tx_empty cleared", irq_status[2], 0);
        setmask(8'h02);
        chk("R11 irq low", irq, 0);
        nsent = 0;
        @(negedge clk); tx_en = 1;
        idle(6);
        tx_en = 0;
        chk("R8 sent count", nsent, 3);
        chk("R8 order0", sent[0], 2);
        chk("R8 order1", sent[1], 0);
        chk("R8 order2", sent[2], 1);
        chk("R8 tx_empty set", irq_status[2], 1);
        chk("R9 done head", done_head, 2);
        chk("R9 tx flag", irq_status[1], 1);
        chk("R11 irq high", irq, 1);
        chk("R9 pages kept", used_count, 3);
        ack(8'h02);
        chk("R10 pop done", done_head, 0);
        chk("R10 tx reasserted", irq_status[1], 1);
        ack(8'h02);
        ack(8'h02);
        chk("R10 done empty", done_head, 8'h80);
        chk("R10 tx cleared", irq_status[1], 0);
        chk("R11 irq dropped", irq, 0);

        // R9 auto release
        cmd(8'h40);
        cmd(8'h20);
        pnum(8'd0);
        @(negedge clk); auto_release = 1; tx_en = 1;
        cmd(8'hC0);
        idle(3);
        tx_en = 0; auto_release = 0;
        chk("R9 auto freed", used_count, 0);
        chk("R9 auto no done", done_head, 8'h80);

        // R7 full enqueue ignored, R12 clear commands
        cmd(8'h40);
        repeat (NP) cmd(8'h20);
        for (int p = 0; p < NP; p++) begin
            pnum(8'(p)); cmd(8'hC0);
        end
        pnum(8'd1); cmd(8'hC0);
        nsent = 0;
        @(negedge clk); tx_en = 1;
        idle(8);
        tx_en = 0;
        chk("R7 full ignored count", nsent, 4);
        chk("R7 last sent", sent[3], 3);
        chk("R9 done head first", done_head, 0);
        cmd(8'hE0);
        chk("R12 txclr done", done_head, 8'h80);
        chk("R12 txclr pages", used_count, 4);
        cmd(8'h40);
        chk("R12 reset pages", used_count, 0);
        chk("R12 reset result", alloc_result, 0);

        // R10 ack mask, R11 mask
        cmd(8'h20);
        rxreq();
        ack(8'hFF);
        chk("R10 ack mask", irq_status, 8'h0D);
        setmask(8'h08);
        chk("R11 mask read", irq_mask, 8'h08);
        chk("R11 irq alloc", irq, 1);
        setmask(8'h10);
        chk("R11 irq masked", irq, 0);

        // R13 low bits ignored
        cmd(8'h40);
        cmd(8'h1F);
        chk("R13 nop used", used_count, 0);
        chk("R13 nop result", alloc_result, 0);
        cmd(8'h3F);
        chk("R13 alloc low bits", used_count, 1);
        chk("R13 alloc result", alloc_result, 0);

        finished = 1;
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end
endmodule